// File: doc/BRIEF.md
# Control OUT Data-Stage Handshake Tracker

This block decides the handshake returned to the host for each OUT data packet in the data stage of a control transfer. The endpoint's maximum packet size is 8 bytes. A packet-receive interface reports the end of each packet, its byte count and whether it arrived with a CRC or bit-stuff error. A CPU-side command interface clears the buffer-ready flag, marks the data stage as finished, and forces a stall. The block answers each good packet with ACK, NAK or STALL.

The firmware reads the data once a short packet has raised the buffer-ready flag. It then clears the flag and marks the data stage finished. From that point on, any further host data is refused with STALL and no firmware action is needed. Packets that arrive before that point are acknowledged even when they exceed the expected length. It is then up to the firmware to notice the excess and force a stall. A SETUP token opens a fresh transfer, and a bus reset clears everything.

Top module: `ctl_out_stall_tracker`

## Requirements
- R1: After reset the buffer-ready output is 0 and no handshake is presented (hs_valid_o = 0, hs_code_o = 2'b00).
- R2: A good packet with fewer than 8 bytes, arriving while buffer-ready, finished and forced-stall are all clear, is answered with ACK (code 2'b01). Buffer-ready reads 1 from the cycle after the end-of-packet strobe.
- R3: A good packet of 8 bytes, arriving while all three flags are clear, is answered with ACK and leaves buffer-ready at 0. Any number of such packets beyond the expected length are all ACKed.
- R4: A good packet that arrives while buffer-ready is 1, with finished and forced-stall clear, is answered with NAK (code 2'b10). Buffer-ready stays 1.
- R5: A CPU write with the clear-ready bit set drives buffer-ready to 0 in the next cycle.
- R6: Once the CPU has written the data-end bit, every later good packet is answered with STALL (code 2'b11) and buffer-ready is left unchanged.
- R7: Once the CPU has written the send-stall bit, every later good packet is answered with STALL. This takes priority over NAK.
- R8: A packet flagged with an error gets no handshake and changes no flag.
- R9: A SETUP token clears the finished and forced-stall flags. Buffer-ready is kept. An end-of-packet strobe in the same cycle as the SETUP token is ignored.
- R10: A bus reset clears buffer-ready, finished and forced-stall, and suppresses any handshake in that cycle.
- R11: The handshake output is a one-cycle pulse. hs_valid_o is 1 exactly in the cycle after an accepted end-of-packet strobe, and at all other times it is 0 with code 2'b00.
- R12: A packet always sees the flags as they stood before any CPU write in the same cycle. If a short ACKed packet and a clear-ready write coincide, buffer-ready ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | USB bus reset seen on the line |
| setup_tok_i | input | 1 | A new SETUP token was received |
| pkt_end_i | input | 1 | End-of-packet strobe for an OUT data packet |
| pkt_len_i | input | LEN_W (4) | Byte count of the packet |
| pkt_err_i | input | 1 | Packet had a CRC or bit-stuff error |
| cpu_wr_i | input | 1 | CPU writes the command bits this cycle |
| cpu_clr_rdy_i | input | 1 | Command: clear buffer-ready |
| cpu_data_end_i | input | 1 | Command: mark data stage finished |
| cpu_send_stall_i | input | 1 | Command: force STALL |
| buf_rdy_o | output | 1 | Buffer-ready flag for the CPU |
| hs_valid_o | output | 1 | Handshake is presented this cycle |
| hs_code_o | output | 2 | 01 ACK, 10 NAK, 11 STALL, 00 none |

## Verification
A strobe or command sampled at one clock edge shows up on every output right after that edge: the handshake pulse, its code and the new buffer-ready value each sit behind one register. The bench drives inputs on the falling edge. At each rising edge it advances a behavioural model of the three flags and the pending handshake, then compares all outputs a short delay later. This makes the one-cycle latency part of every comparison. Idle cycles are compared as well, so a pulse that lasts too long or appears without a cause is caught.

// File: rtl/ctl_out_pkg.sv
package ctl_out_pkg;

  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_code_e;

  typedef struct packed {
    logic rdy;
    logic data_end;
    logic send_stall;
  } ep_flags_t;

endpackage

// File: rtl/ctl_out_rst_sync.sv
module ctl_out_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync_o = sync_q[STAGES-1];

endmodule

// File: rtl/ctl_out_hs_sel.sv
module ctl_out_hs_sel
  import ctl_out_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ep_flags_t flags_i,
  input  logic      pkt_end_i,
  input  logic      pkt_err_i,
  input  logic      pkt_short_i,
  input  logic      setup_tok_i,
  input  logic      bus_reset_i,
  output logic      set_rdy_o,
  output logic      hs_valid_o,
  output hs_code_e  hs_code_o
);

  logic     pkt_go;
  hs_code_e code_d;
  logic     valid_d;
  hs_code_e code_n;
  logic     valid_q;
  hs_code_e code_q;

  always_comb begin
    pkt_go = pkt_end_i && !pkt_err_i && !setup_tok_i && !bus_reset_i;
    if (flags_i.send_stall || flags_i.data_end) begin
      code_d = HS_STALL;
    end else if (flags_i.rdy) begin
      code_d = HS_NAK;
    end else begin
      code_d = HS_ACK;
    end
    set_rdy_o = pkt_go && (code_d == HS_ACK) && pkt_short_i;
    valid_d   = pkt_go;
    code_n    = pkt_go ? code_d : HS_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= HS_NONE;
    end else begin
      valid_q <= valid_d;
      code_q  <= code_n;
    end
  end

  assign hs_valid_o = valid_q;
  assign hs_code_o  = code_q;

  a_r8_err_no_hs: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_end_i && pkt_err_i) |=> !hs_valid_o);

  a_r11_code_none_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_valid_o |-> (hs_code_o == HS_NONE));

endmodule

// File: rtl/ctl_out_flags.sv
module ctl_out_flags
  import ctl_out_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bus_reset_i,
  input  logic      setup_tok_i,
  input  logic      cpu_wr_i,
  input  logic      cpu_clr_rdy_i,
  input  logic      cpu_data_end_i,
  input  logic      cpu_send_stall_i,
  input  logic      set_rdy_i,
  output ep_flags_t flags_o
);

  ep_flags_t flags_q;
  ep_flags_t flags_n;
  logic      flags_en;

  always_comb begin
    flags_n  = flags_q;
    flags_en = bus_reset_i || setup_tok_i || cpu_wr_i || set_rdy_i;
    if (cpu_wr_i && cpu_clr_rdy_i) begin
      flags_n.rdy = 1'b0;
    end
    if (set_rdy_i) begin
      flags_n.rdy = 1'b1;
    end
    if (cpu_wr_i && cpu_data_end_i) begin
      flags_n.data_end = 1'b1;
    end
    if (cpu_wr_i && cpu_send_stall_i) begin
      flags_n.send_stall = 1'b1;
    end
    if (setup_tok_i) begin
      flags_n.data_end   = 1'b0;
      flags_n.send_stall = 1'b0;
    end
    if (bus_reset_i) begin
      flags_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_n;
    end
  end

  assign flags_o = flags_q;

  a_r9_setup_clears: assert property (@(posedge clk) disable iff (!rst_n)
    setup_tok_i |=> (!flags_o.data_end && !flags_o.send_stall));

  a_r5_clr_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr_i && cpu_clr_rdy_i && !set_rdy_i) |=> !flags_o.rdy);

  a_r6_data_end_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o.data_end && !setup_tok_i && !bus_reset_i) |=> flags_o.data_end);

endmodule

// File: rtl/ctl_out_stall_tracker.sv
module ctl_out_stall_tracker
  import ctl_out_pkg::*;
#(
  parameter int MAXP  = 8,
  parameter int LEN_W = $clog2(MAXP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset_i,
  input  logic             setup_tok_i,
  input  logic             pkt_end_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  input  logic             pkt_err_i,
  input  logic             cpu_wr_i,
  input  logic             cpu_clr_rdy_i,
  input  logic             cpu_data_end_i,
  input  logic             cpu_send_stall_i,
  output logic             buf_rdy_o,
  output logic             hs_valid_o,
  output logic [1:0]       hs_code_o
);

  localparam logic [LEN_W-1:0] MAXP_LEN = LEN_W'(MAXP);
  localparam int RST_STAGES = 2;

  logic      rst_n_int;
  ep_flags_t flags;
  logic      set_rdy;
  logic      pkt_short;
  hs_code_e  hs_code;

  assign pkt_short = (pkt_len_i < MAXP_LEN);

  ctl_out_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_n_sync_o (rst_n_int)
  );

  ctl_out_flags u_flags (
    .clk              (clk),
    .rst_n            (rst_n_int),
    .bus_reset_i      (bus_reset_i),
    .setup_tok_i      (setup_tok_i),
    .cpu_wr_i         (cpu_wr_i),
    .cpu_clr_rdy_i    (cpu_clr_rdy_i),
    .cpu_data_end_i   (cpu_data_end_i),
    .cpu_send_stall_i (cpu_send_stall_i),
    .set_rdy_i        (set_rdy),
    .flags_o          (flags)
  );

  ctl_out_hs_sel u_hs_sel (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .flags_i     (flags),
    .pkt_end_i   (pkt_end_i),
    .pkt_err_i   (pkt_err_i),
    .pkt_short_i (pkt_short),
    .setup_tok_i (setup_tok_i),
    .bus_reset_i (bus_reset_i),
    .set_rdy_o   (set_rdy),
    .hs_valid_o  (hs_valid_o),
    .hs_code_o   (hs_code)
  );

  assign buf_rdy_o = flags.rdy;
  assign hs_code_o = hs_code;

  a_r11_valid_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n_int)
    hs_valid_o |-> $past(pkt_end_i));

  a_r10_bus_reset: assert property (@(posedge clk) disable iff (!rst_n_int)
    bus_reset_i |=> (!buf_rdy_o && !hs_valid_o));

  a_r6_stall_after_end: assert property (@(posedge clk) disable iff (!rst_n_int)
    (flags.data_end && pkt_end_i && !pkt_err_i && !setup_tok_i && !bus_reset_i)
      |=> (hs_code_o == 2'b11));

  a_r4_nak_keeps_rdy: assert property (@(posedge clk) disable iff (!rst_n_int)
    (hs_valid_o && hs_code_o == 2'b10) |-> $past(buf_rdy_o));

  a_r2_short_sets_rdy: assert property (@(posedge clk) disable iff (!rst_n_int)
    (pkt_end_i && !pkt_err_i && !setup_tok_i && !bus_reset_i && pkt_short
     && !buf_rdy_o && !flags.data_end && !flags.send_stall) |=> buf_rdy_o);

endmodule

// File: tb/ctl_out_stall_tracker_tb.sv
module ctl_out_stall_tracker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int MAXP = 8;
  localparam int LEN_W = 4;

  logic clk;
  logic rst_n;
  logic bus_reset_i, setup_tok_i, pkt_end_i, pkt_err_i;
  logic [LEN_W-1:0] pkt_len_i;
  logic cpu_wr_i, cpu_clr_rdy_i, cpu_data_end_i, cpu_send_stall_i;
  logic buf_rdy_o, hs_valid_o;
  logic [1:0] hs_code_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string cur_req = "R1";

  int m_rdy = 0, m_de = 0, m_ss = 0, m_hsv = 0, m_hs = 0;

  ctl_out_stall_tracker #(.MAXP(MAXP), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i), .setup_tok_i(setup_tok_i),
    .pkt_end_i(pkt_end_i), .pkt_len_i(pkt_len_i), .pkt_err_i(pkt_err_i),
    .cpu_wr_i(cpu_wr_i), .cpu_clr_rdy_i(cpu_clr_rdy_i), .cpu_data_end_i(cpu_data_end_i),
    .cpu_send_stall_i(cpu_send_stall_i), .buf_rdy_o(buf_rdy_o),
    .hs_valid_o(hs_valid_o), .hs_code_o(hs_code_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("buf_rdy_o", int'(buf_rdy_o), m_rdy);
    chk("hs_valid_o", int'(hs_valid_o), m_hsv);
    chk("hs_code_o", int'(hs_code_o), m_hs);
  endtask

  task automatic model_step();
    int go, code;
    go = (pkt_end_i && !pkt_err_i && !setup_tok_i && !bus_reset_i) ? 1 : 0;
    if (m_ss != 0 || m_de != 0) code = 3;
    else if (m_rdy != 0) code = 2;
    else code = 1;
    m_hsv = go;
    m_hs  = go ? code : 0;
    if (cpu_wr_i && cpu_clr_rdy_i) m_rdy = 0;
    if (go && code == 1 && int'(pkt_len_i) < MAXP) m_rdy = 1;
    if (cpu_wr_i && cpu_data_end_i) m_de = 1;
    if (cpu_wr_i && cpu_send_stall_i) m_ss = 1;
    if (setup_tok_i) begin m_de = 0; m_ss = 0; end
    if (bus_reset_i) begin m_rdy = 0; m_de = 0; m_ss = 0; m_hsv = 0; m_hs = 0; end
  endtask

  task automatic cyc(bit pe, int len, bit err, bit setup, bit br,
                     bit wr, bit clr, bit de, bit ss);
    @(negedge clk);
    pkt_end_i = pe; pkt_len_i = LEN_W'(len); pkt_err_i = err;
    setup_tok_i = setup; bus_reset_i = br;
    cpu_wr_i = wr; cpu_clr_rdy_i = clr; cpu_data_end_i = de; cpu_send_stall_i = ss;
    @(posedge clk);
    model_step();
    #1;
    compare_all();
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic pkt(int len);
    cyc(1, len, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic cpu(bit clr, bit de, bit ss);
    cyc(0, 0, 0, 0, 0, 1, clr, de, ss);
  endtask

  initial begin
    rst_n = 1'b0;
    bus_reset_i = 0; setup_tok_i = 0; pkt_end_i = 0; pkt_len_i = '0; pkt_err_i = 0;
    cpu_wr_i = 0; cpu_clr_rdy_i = 0; cpu_data_end_i = 0; cpu_send_stall_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R1"; compare_all(); idle(); idle();

    cur_req = "R2"; pkt(2); idle();
    cur_req = "R4"; pkt(8); pkt(3); idle();
    cur_req = "R8"; cyc(1, 8, 1, 0, 0, 0, 0, 0, 0); idle();
    cur_req = "R5"; cpu(1, 0, 0); idle();
    cur_req = "R3"; pkt(8); pkt(8); pkt(8); pkt(8); pkt(8); pkt(8); idle();
    cur_req = "R8"; cyc(1, 2, 1, 0, 0, 0, 0, 0, 0); idle();
    cur_req = "R2"; pkt(0); idle();
    cur_req = "R12"; cyc(1, 3, 0, 0, 0, 1, 1, 0, 0); idle();
    cyc(1, 8, 0, 0, 0, 1, 1, 0, 0); idle();
    cyc(1, 1, 0, 0, 0, 1, 1, 0, 0); idle();
    cur_req = "R6"; cpu(1, 1, 0); pkt(8); pkt(0); pkt(5); idle();
    cur_req = "R9"; cyc(1, 2, 0, 1, 0, 0, 0, 0, 0); pkt(8); idle();
    cur_req = "R7"; cpu(0, 0, 1); pkt(8); idle();
    cur_req = "R9"; cyc(0, 0, 0, 1, 0, 0, 0, 0, 0); pkt(4); idle();
    cur_req = "R7"; cpu(0, 0, 1); pkt(4); idle();
    cur_req = "R10"; cpu(0, 1, 0); cyc(1, 2, 0, 0, 1, 0, 0, 0, 0); idle();
    pkt(8); pkt(2); idle();
    cur_req = "R11"; idle(); pkt(8); idle(); idle();
    cur_req = "R8"; cpu(1, 0, 0); cyc(1, 1, 1, 0, 0, 0, 0, 0, 0); idle();

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule